// File: doc/BRIEF.md
# Eight-Point Inverse Cosine Transform, Split-Parity Form

This block turns one vector of eight signed frequency-domain coefficients into eight signed spatial samples, the one-dimensional step of an inverse cosine transform. It does not multiply by one dense 8x8 matrix. The coefficients at even positions go through one 4x4 constant matrix and those at odd positions through a second 4x4 constant matrix. Each element of the two resulting 4-element vectors is an inner product of four inputs with one row of constants. A final add/subtract stage folds the two vectors into the eight outputs.

The datapath has three register stages: products, inner-product sums, and butterfly with rounding. It takes a new vector on every clock cycle as long as the consumer keeps accepting results. Both sides use a valid/ready handshake. When the output side stalls, the whole pipeline freezes and holds its contents. A two-dimensional transform is built by running row and column passes through one or more copies of this block.

Top module: `idct8_eo`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: The even term for output row n (0..3) is e[n] = sum over j=0..3 of B(n,2j)*X[2j], where X[k] is `in_data[k*12 +: 12]` (signed). B(n,0)=1448, and for k>0 B(n,k)=round(2048*cos((2n+1)*k*pi/16)).
- R3: The odd term is o[n] = sum over j=0..3 of B(n,2j+1)*X[2j+1], using the same B as in R2.
- R4: Output sample Y[n] is formed from e[n]+o[n] and output sample Y[7-n] is formed from e[n]-o[n], for n=0..3. Y[k] is `out_data[k*16 +: 16]`.
- R5: Each butterfly result v gives (v + 2048) arithmetically shifted right by 12.
- R6: Each rounded result is clamped to the range [-32768, 32767]. Full-scale inputs of either sign give the exact clamped value.
- R7: An all-zero input vector gives exactly zero on all eight outputs.
- R8: When the output is never stalled, a vector accepted at clock edge t is presented on the output after edge t+2, so it is taken at edge t+3.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output vector and `out_valid` hold unchanged.
- R10: Results leave in acceptance order, one for each accepted vector, with no loss, duplication or spurious output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector is present |
| in_ready | output | 1 | Block accepts the input vector this cycle |
| in_data | input | 96 | Eight signed 12-bit coefficients, position k at bits k*12 |
| out_valid | output | 1 | Output vector is present |
| out_ready | input | 1 | Consumer takes the output vector this cycle |
| out_data | output | 128 | Eight signed 16-bit samples, position k at bits k*16 |

## Verification
The checker assumes that the consumer follows the handshake: `out_ready` can be low for any number of cycles, but each result counts as delivered only on a cycle where both valid and ready are high. It also assumes that the producer's `in_data` matters only when a transfer happens. The stimulus sometimes changes `in_data` and `in_valid` while `in_ready` is low, and it drives `out_ready` both continuously high and with a random pattern, so the stall-hold and occupancy checks see both conditions. The coefficient patterns include single-position impulses, all-zero vectors, full-scale vectors of both signs and random vectors.

// File: rtl/idct8_pkg.sv
package idct8_pkg;
   // fixed-point scale of the basis constants
   localparam int FRAC = 12;

   // half-amplitude cosine magnitudes cos(m*pi/16)/2 scaled by 2^FRAC
   function automatic int half_cos(input int m);
      case (m)
         0: return 2048;
         1: return 2009;
         2: return 1892;
         3: return 1703;
         4: return 1448;
         5: return 1138;
         6: return 784;
         7: return 400;
         default: return 0;
      endcase
   endfunction

   // basis entry for output row n and frequency k
   function automatic int basis(input int n, input int k);
      int m;
      if (k == 0) return half_cos(4);
      m = ((2 * n + 1) * k) % 32;
      if (m > 16) m = 32 - m;
      if (m > 8) return -half_cos(16 - m);
      return half_cos(m);
   endfunction
endpackage

// File: rtl/idct8_mult.sv
module idct8_mult #(
   parameter int IN_W   = 12,
   parameter int COEF_W = 14,
   parameter int PROD_W = IN_W + COEF_W
) (
   input  logic                     clk,
   input  logic                     en,
   input  logic [8*IN_W-1:0]        x_flat,
   output logic signed [PROD_W-1:0] prod [2][4][4]
);
   // h = 0 even half, h = 1 odd half; row n, column j
   for (genvar h = 0; h < 2; h++) begin : g_half
      for (genvar n = 0; n < 4; n++) begin : g_row
         for (genvar j = 0; j < 4; j++) begin : g_col
            localparam int K = 2 * j + h;
            localparam logic signed [COEF_W-1:0] CF = COEF_W'(idct8_pkg::basis(n, K));
            logic signed [IN_W-1:0] xv;
            assign xv = x_flat[K*IN_W +: IN_W];
            always_ff @(posedge clk) begin
               if (en) prod[h][n][j] <= PROD_W'(xv) * PROD_W'(CF);
            end
         end
      end
   end
endmodule

// File: rtl/idct8_sum.sv
module idct8_sum #(
   parameter int PROD_W = 26,
   parameter int SUM_W  = PROD_W + 2
) (
   input  logic                     clk,
   input  logic                     en,
   input  logic signed [PROD_W-1:0] prod [2][4][4],
   output logic signed [SUM_W-1:0]  acc  [2][4]
);
   for (genvar h = 0; h < 2; h++) begin : g_half
      for (genvar n = 0; n < 4; n++) begin : g_row
         always_ff @(posedge clk) begin
            if (en) acc[h][n] <= SUM_W'(prod[h][n][0]) + SUM_W'(prod[h][n][1])
                               + SUM_W'(prod[h][n][2]) + SUM_W'(prod[h][n][3]);
         end
      end
   end
endmodule

// File: rtl/idct8_butterfly.sv
module idct8_butterfly #(
   parameter int SUM_W = 28,
   parameter int OUT_W = 16,
   parameter int FRAC  = 12
) (
   input  logic                    clk,
   input  logic                    en,
   input  logic signed [SUM_W-1:0] acc [2][4],
   output logic [8*OUT_W-1:0]      y_flat
);
   localparam int BF_W = SUM_W + 1;
   localparam logic signed [BF_W-1:0] HALF = BF_W'(64'sd1 <<< (FRAC - 1));
   localparam logic signed [BF_W-1:0] MAXV = BF_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
   localparam logic signed [BF_W-1:0] MINV = -MAXV - BF_W'(1);

   if (BF_W - FRAC <= OUT_W) begin : g_nosat_check
      $error("butterfly width too small for clamping");
   end

   for (genvar n = 0; n < 4; n++) begin : g_row
      for (genvar s = 0; s < 2; s++) begin : g_side
         // s = 0 gives the front sample, s = 1 the mirrored one
         localparam int IDX = (s == 0) ? n : 7 - n;
         logic signed [BF_W-1:0] bf, rnd, q;
         logic signed [OUT_W-1:0] sat;
         always_comb begin
            if (s == 0) bf = BF_W'(acc[0][n]) + BF_W'(acc[1][n]);
            else        bf = BF_W'(acc[0][n]) - BF_W'(acc[1][n]);
            rnd = bf + HALF;
            q   = rnd >>> FRAC;
            if (q > MAXV)      sat = MAXV[OUT_W-1:0];
            else if (q < MINV) sat = MINV[OUT_W-1:0];
            else               sat = q[OUT_W-1:0];
         end
         always_ff @(posedge clk) begin
            if (en) y_flat[IDX*OUT_W +: OUT_W] <= sat;
         end
      end
   end
endmodule

// File: rtl/idct8_eo.sv
module idct8_eo #(
   parameter int IN_W   = 12,
   parameter int COEF_W = 14,
   parameter int OUT_W  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [8*IN_W-1:0]    in_data,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [8*OUT_W-1:0]   out_data
);
   localparam int FRAC   = idct8_pkg::FRAC;
   localparam int PROD_W = IN_W + COEF_W;
   localparam int SUM_W  = PROD_W + 2;

   if (IN_W < 2 || COEF_W < 13 || OUT_W < 2 || SUM_W + 1 > 63) begin : g_param_check
      $error("idct8_eo: unsupported width parameters");
   end

   logic advance;
   logic v1, v2;
   logic signed [PROD_W-1:0] prod [2][4][4];
   logic signed [SUM_W-1:0]  acc  [2][4];

   // the whole pipeline moves together unless the last stage is held
   assign advance  = !out_valid || out_ready;
   assign in_ready = advance;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1        <= 1'b0;
         v2        <= 1'b0;
         out_valid <= 1'b0;
      end else if (advance) begin
         v1        <= in_valid;
         v2        <= v1;
         out_valid <= v2;
      end
   end

   idct8_mult #(.IN_W(IN_W), .COEF_W(COEF_W), .PROD_W(PROD_W)) u_mult (
      .clk(clk), .en(advance), .x_flat(in_data), .prod(prod));

   idct8_sum #(.PROD_W(PROD_W), .SUM_W(SUM_W)) u_sum (
      .clk(clk), .en(advance), .prod(prod), .acc(acc));

   idct8_butterfly #(.SUM_W(SUM_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_bfly (
      .clk(clk), .en(advance), .acc(acc), .y_flat(out_data));
endmodule

// File: rtl/idct8_eo_chk.sv
module idct8_eo_chk #(
   parameter int OUT_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic [8*OUT_W-1:0] out_data
);
   logic [2:0] inflight;
   logic       fire_in, fire_out;
   assign fire_in  = in_valid && in_ready;
   assign fire_out = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight + 3'(fire_in) - 3'(fire_out);
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire_in ##1 in_ready ##1 in_ready |=> out_valid);

   assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> inflight != 3'd0);

   assert_occupancy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= 3'd3);
endmodule

bind idct8_eo idct8_eo_chk #(.OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

// File: tb/tb_idct8_eo.sv
`timescale 1ns/1ps
module tb_idct8_eo;
   localparam int IW = 12;
   localparam int OW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [8*IW-1:0] in_data = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [8*OW-1:0] out_data;

   always #2 clk = ~clk;

   idct8_eo dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
                 .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
                 .out_data(out_data));

   int errors = 0, checks = 0, cyc = 0, stalls = 0;
   bit rdy_random = 0;
   bit prev_hold = 0;
   logic [8*OW-1:0] prev_out;
   logic [8*OW-1:0] exp_q[$];
   string tag_q[$];
   int acc_q[$];
   int stall_q[$];
   bit finished = 0;

   function automatic longint entry(int n, int k);
      real r;
      if (k == 0) r = 4096.0 * 0.5 / $sqrt(2.0);
      else        r = 2048.0 * $cos((2 * n + 1) * k * 3.14159265358979 / 16.0);
      if (r >= 0.0) return longint'($rtoi(r + 0.5));
      return -longint'($rtoi(-r + 0.5));
   endfunction

   function automatic longint finish_val(longint v);
      longint q;
      q = (v + 2048) >>> 12;
      if (q > 32767) q = 32767;
      if (q < -32768) q = -32768;
      return q;
   endfunction

   function automatic logic [8*OW-1:0] model(logic [8*IW-1:0] d);
      longint x[8];
      longint e, o;
      logic [8*OW-1:0] y;
      for (int k = 0; k < 8; k++) x[k] = longint'($signed(d[k*IW +: IW]));
      for (int n = 0; n < 4; n++) begin
         e = 0; o = 0;
         for (int j = 0; j < 4; j++) begin
            e += entry(n, 2 * j) * x[2 * j];
            o += entry(n, 2 * j + 1) * x[2 * j + 1];
         end
         y[n*OW +: OW]       = OW'(finish_val(e + o));
         y[(7-n)*OW +: OW]   = OW'(finish_val(e - o));
      end
      return y;
   endfunction

   task automatic check(bit ok, string req, string what, logic [8*OW-1:0] act, logic [8*OW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one cycle: drive at the falling edge, evaluate what the next rising edge will do
   task automatic step(input bit v, input logic [8*IW-1:0] d, input string tag, output bit took);
      logic [8*OW-1:0] e;
      int a, s;
      string t;
      @(negedge clk);
      in_valid  = v;
      in_data   = d;
      out_ready = rdy_random ? ($urandom % 4 != 0) : 1'b1;
      #1;
      if (prev_hold)
         check(out_valid && out_data == prev_out, "R9", "held output", out_data, prev_out);
      check(in_ready == (!out_valid || out_ready), "R9", "in_ready rule",
            {127'd0, in_ready}, {127'd0, !out_valid || out_ready});
      if (out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(0, "R10", "spurious output", out_data, '0);
         end else begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
            a = acc_q.pop_front(); s = stall_q.pop_front();
            check(out_data == e, t, "sample vector", out_data, e);
            if (s == stalls)
               check(cyc - a == 3, "R8", "latency", 128'(cyc - a), 128'd3);
         end
      end
      prev_hold = out_valid && !out_ready;
      prev_out  = out_data;
      if (prev_hold) stalls++;
      took = v && in_ready;
      if (took) begin
         exp_q.push_back(model(d)); tag_q.push_back(tag);
         acc_q.push_back(cyc); stall_q.push_back(stalls);
      end
      cyc++;
   endtask

   task automatic send(input logic [8*IW-1:0] d, input string tag);
      bit took;
      do step(1'b1, d, tag, took); while (!took);
   endtask

   task automatic idle(input int n);
      bit took;
      for (int i = 0; i < n; i++) step(1'b0, {8*IW{1'b1}}, "", took);
   endtask

   function automatic logic [8*IW-1:0] pack(int a0, int a1, int a2, int a3,
                                             int a4, int a5, int a6, int a7);
      return {IW'(a7), IW'(a6), IW'(a5), IW'(a4), IW'(a3), IW'(a2), IW'(a1), IW'(a0)};
   endfunction

   initial begin
      #40000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [8*IW-1:0] v;
      repeat (3) @(negedge clk);
      #1;
      check(!out_valid && in_ready, "R1", "in reset", {126'd0, out_valid, in_ready}, 128'd1);
      @(negedge clk); rst_n = 1'b1; #1;
      check(!out_valid && in_ready, "R1", "after reset", {126'd0, out_valid, in_ready}, 128'd1);

      // R7 zero vectors, R8 latency measured with steady ready
      send('0, "R7"); idle(4);
      send('0, "R7");
      // R2 even-position impulses, R3 odd-position impulses
      for (int k = 0; k < 8; k++) begin
         v = '0; v[k*IW +: IW] = IW'(k % 2 == 0 ? 1000 : -700);
         send(v, (k % 2 == 0) ? "R2" : "R3");
      end
      idle(4);
      // R4 mixed halves, R5 rounding near half steps
      send(pack(1, 0, 0, 0, 0, 0, 0, 0), "R5");
      send(pack(-3, 5, -7, 9, 11, -13, 2, -1), "R5");
      send(pack(512, 300, -200, 100, 64, -50, 25, -12), "R4");
      // R6 full-scale inputs of both signs
      send(pack(2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047), "R6");
      send(pack(-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048), "R6");
      send(pack(2047, -2048, 2047, -2048, 2047, -2048, 2047, -2048), "R6");
      send(pack(-2048, 2047, -2048, 2047, -2048, 2047, -2048, 2047), "R6");
      idle(5);
      // R9 and R10 under random backpressure and input gaps
      rdy_random = 1;
      for (int i = 0; i < 300; i++) begin
         bit took;
         v = {$urandom, $urandom, $urandom};
         if ($urandom % 3 == 0) step(1'b0, v, "", took);
         else send(v, "R10");
      end
      rdy_random = 0;
      idle(8);
      check(exp_q.size() == 0, "R10", "all results delivered",
            128'(exp_q.size()), 128'd0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule